// File: doc/BRIEF.md
# Serial Shift Slice with Double-Buffered Word Swap

This block is one slice of a serial I/O engine. A reloading down-counter sets the bit rate. Each time the counter passes zero, the slice performs a shift step. In a shift step a 32-bit live word moves one place toward bit 0, its top bit takes the level on the serial input, and the serial output shows the live word's lowest bit. A second counter counts shift steps. When that counter runs out, the live word and a shadow word trade places in one cycle. Software can therefore load the next word to transmit, or collect the last word received, while the stream keeps running without a gap.

Software reaches the slice through a flat register port with one address bus. Writes are synchronous, and reads are combinational from the addressed register. The port holds the live word, the shadow word, the rate preset, the rate counter, the step counter and its reload value. It also has strobes that start and stop the slice, and controls for a shift interrupt flag and its enable.

Top module: `serial_shift_slice`

## Requirements
- R1: After reset, every readable register reads 0 and both `sout` and `irq` are low.
- R2: While the slice runs and the rate counter is not 0, the counter drops by one each cycle. While the slice is stopped, the counter holds unless software writes it.
- R3: A running slice whose rate counter is 0 makes a shift step in that cycle and reloads the counter from the preset. Shift steps therefore come every preset+1 cycles.
- R4: In a shift step the live word becomes {sin, live[31:1]}.
- R5: `sout` always equals bit 0 of the live word.
- R6: In a shift step the step counter decrements if it is nonzero. If it is 0, it reloads from the reload register and a swap happens: the live word takes the old shadow word, and the shadow word takes the shifted live word of R4.
- R7: A write of 1 in bit 0 to address 6 starts the slice, and a write of 1 in bit 0 to address 7 stops it. A write of 0 to either address changes nothing. Reading address 6 or 7 returns the run state in bit 0.
- R8: Every shift step sets the status flag. Writing 1 in bit 0 to address 10 sets the flag, and writing 1 in bit 0 to address 11 clears it. A shift step in the same cycle as a clear wins.
- R9: Writing 1 in bit 0 to address 8 sets the interrupt enable, and writing 1 in bit 0 to address 9 clears it. `irq` is high exactly while both the status flag and the enable are 1.
- R10: A software write to the live word, or to the rate counter, in a cycle that also has a shift step is discarded, and the hardware update is kept.
- R11: The register addresses are 0 live word, 1 shadow word, 2 preset, 3 rate counter, 4 step counter and 5 step reload. Reading address 8 or 9 returns the enable in bit 0, and reading address 10 or 11 returns the status in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sin | input | 1 | Serial input bit |
| sout | output | 1 | Serial output, bit 0 of the live word |
| irq | output | 1 | Shift interrupt, status AND enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the addressed register |

## Verification
A register write takes effect at the clock edge that samples it, and its readback is combinational. The bench therefore drives on a falling edge and checks on the next falling edge. The slice is started at a known edge E with the rate counter at 0, so shift steps fall on edges E+1, E+1+(P+1) and so on for preset P. Each check waits exactly that number of falling edges and reads the word before the next step can land. The conflict cases are timed so the write lands on a known step edge: a live-word write, and a status clear. A control write on a neighbouring non-step edge shows the write path itself works.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_LIVE     = 4'd0,
    A_SHADOW   = 4'd1,
    A_PRESET   = 4'd2,
    A_COUNT    = 4'd3,
    A_STEP     = 4'd4,
    A_RELOAD   = 4'd5,
    A_RUN_SET  = 4'd6,
    A_RUN_CLR  = 4'd7,
    A_IEN_SET  = 4'd8,
    A_IEN_CLR  = 4'd9,
    A_STAT_SET = 4'd10,
    A_STAT_CLR = 4'd11
  } sss_addr_e;

  typedef struct packed {
    logic live_wr;
    logic shadow_wr;
    logic preset_wr;
    logic cnt_wr;
    logic step_wr;
    logic reload_wr;
    logic run_set;
    logic run_clr;
    logic ien_set;
    logic ien_clr;
    logic stat_set;
    logic stat_clr;
  } sss_strobe_t;
endpackage

// File: rtl/sss_rst_sync.sv
module sss_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain[g] <= 1'b0;
          else           chain[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n_in) begin
          if (!rst_n_in) chain[g] <= 1'b0;
          else           chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign rst_n_out = chain[STAGES-1];
endmodule

// File: rtl/sss_ctrl_port.sv
module sss_ctrl_port
  import sss_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int POS_W  = 8
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wbit0,
  input  logic [DATA_W-1:0] live,
  input  logic [DATA_W-1:0] shadow,
  input  logic [CNT_W-1:0]  preset,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [POS_W-1:0]  step,
  input  logic [POS_W-1:0]  reload,
  input  logic              run,
  input  logic              ien,
  input  logic              status,
  output sss_strobe_t       stb,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    stb = '0;
    if (wr_en) begin
      unique case (addr)
        A_LIVE:     stb.live_wr   = 1'b1;
        A_SHADOW:   stb.shadow_wr = 1'b1;
        A_PRESET:   stb.preset_wr = 1'b1;
        A_COUNT:    stb.cnt_wr    = 1'b1;
        A_STEP:     stb.step_wr   = 1'b1;
        A_RELOAD:   stb.reload_wr = 1'b1;
        A_RUN_SET:  stb.run_set   = wbit0;
        A_RUN_CLR:  stb.run_clr   = wbit0;
        A_IEN_SET:  stb.ien_set   = wbit0;
        A_IEN_CLR:  stb.ien_clr   = wbit0;
        A_STAT_SET: stb.stat_set  = wbit0;
        A_STAT_CLR: stb.stat_clr  = wbit0;
        default:    stb = '0;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (addr)
      A_LIVE:                 rd_data = live;
      A_SHADOW:               rd_data = shadow;
      A_PRESET:               rd_data = DATA_W'(preset);
      A_COUNT:                rd_data = DATA_W'(cnt);
      A_STEP:                 rd_data = DATA_W'(step);
      A_RELOAD:               rd_data = DATA_W'(reload);
      A_RUN_SET, A_RUN_CLR:   rd_data = DATA_W'(run);
      A_IEN_SET, A_IEN_CLR:   rd_data = DATA_W'(ien);
      A_STAT_SET, A_STAT_CLR: rd_data = DATA_W'(status);
      default:                rd_data = '0;
    endcase
  end
endmodule

// File: rtl/sss_rate_timer.sv
module sss_rate_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_set,
  input  logic             run_clr,
  input  logic             preset_wr,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic             run,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] preset,
  output logic             shift_evt
);
  logic             run_nx, run_en;
  logic [CNT_W-1:0] cnt_nx;
  logic             cnt_en;

  assign shift_evt = run && (cnt == '0);

  always_comb begin
    run_en = run_set | run_clr;
    run_nx = run_set;
  end

  always_comb begin
    cnt_en = shift_evt | cnt_wr | run;
    if (shift_evt)   cnt_nx = preset;
    else if (cnt_wr) cnt_nx = wdata;
    else             cnt_nx = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run    <= 1'b0;
      cnt    <= '0;
      preset <= '0;
    end else begin
      if (run_en)    run    <= run_nx;
      if (cnt_en)    cnt    <= cnt_nx;
      if (preset_wr) preset <= wdata;
    end
  end

  a_r2_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) - 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));
  a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |=> (cnt == $past(preset)));
  a_r7_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> $past(run_set));
endmodule

// File: rtl/sss_step_tracker.sv
module sss_step_tracker #(
  parameter int POS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_evt,
  input  logic             step_wr,
  input  logic             reload_wr,
  input  logic [POS_W-1:0] wdata,
  output logic [POS_W-1:0] step,
  output logic [POS_W-1:0] reload,
  output logic             swap_evt
);
  logic [POS_W-1:0] step_nx;
  logic             step_en;

  assign swap_evt = shift_evt && (step == '0);

  always_comb begin
    step_en = shift_evt | step_wr;
    if (swap_evt)       step_nx = reload;
    else if (shift_evt) step_nx = step - 1'b1;
    else                step_nx = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step   <= '0;
      reload <= '0;
    end else begin
      if (step_en)   step   <= step_nx;
      if (reload_wr) reload <= wdata;
    end
  end

  a_r6_step_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && step == '0) |=> (step == $past(reload)));
  a_r6_step_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && step != '0) |=> (step == $past(step) - 1'b1));
endmodule

// File: rtl/sss_word_path.sv
module sss_word_path #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sin,
  input  logic              shift_evt,
  input  logic              swap_evt,
  input  logic              live_wr,
  input  logic              shadow_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] live,
  output logic [DATA_W-1:0] shadow
);
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] live_nx, shadow_nx;
  logic              live_en, shadow_en;

  assign shifted = {sin, live[DATA_W-1:1]};

  always_comb begin
    live_en = shift_evt | live_wr;
    if (swap_evt)       live_nx = shadow;
    else if (shift_evt) live_nx = shifted;
    else                live_nx = wdata;
  end

  always_comb begin
    shadow_en = swap_evt | shadow_wr;
    if (swap_evt) shadow_nx = shifted;
    else          shadow_nx = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= '0;
      shadow <= '0;
    end else begin
      if (live_en)   live   <= live_nx;
      if (shadow_en) shadow <= shadow_nx;
    end
  end

  a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_evt && !swap_evt) |=> (live == {$past(sin), $past(live[DATA_W-1:1])}));
  a_r6_swap: assert property (@(posedge clk) disable iff (!rst_n)
    swap_evt |=> (live == $past(shadow) &&
                  shadow == {$past(sin), $past(live[DATA_W-1:1])}));
  a_r10_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (live_wr && !shift_evt) |=> (live == $past(wdata)));
endmodule

// File: rtl/sss_irq_flag.sv
module sss_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_evt,
  input  logic stat_set,
  input  logic stat_clr,
  input  logic ien_set,
  input  logic ien_clr,
  output logic status,
  output logic ien,
  output logic irq
);
  logic status_nx, status_en;
  logic ien_nx, ien_en;

  always_comb begin
    status_en = shift_evt | stat_set | stat_clr;
    status_nx = shift_evt | stat_set;
    ien_en    = ien_set | ien_clr;
    ien_nx    = ien_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      ien    <= 1'b0;
    end else begin
      if (status_en) status <= status_nx;
      if (ien_en)    ien    <= ien_nx;
    end
  end

  assign irq = status & ien;

  a_r8_step_sets: assert property (@(posedge clk) disable iff (!rst_n)
    shift_evt |=> status);
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !shift_evt) |=> !status);
endmodule

// File: rtl/serial_shift_slice.sv
module serial_shift_slice
  import sss_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 32,
  parameter int POS_W      = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sin,
  output logic              sout,
  output logic              irq,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic              rst_n_q;
  sss_strobe_t       stb;
  logic [DATA_W-1:0] live, shadow;
  logic [CNT_W-1:0]  cnt, preset;
  logic [POS_W-1:0]  step, reload;
  logic              run, ien, status, shift_evt, swap_evt;

  sss_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_q)
  );

  sss_ctrl_port #(.DATA_W(DATA_W), .CNT_W(CNT_W), .POS_W(POS_W)) u_port (
    .wr_en(wr_en), .addr(addr), .wbit0(wr_data[0]),
    .live(live), .shadow(shadow), .preset(preset), .cnt(cnt),
    .step(step), .reload(reload), .run(run), .ien(ien), .status(status),
    .stb(stb), .rd_data(rd_data)
  );

  sss_rate_timer #(.CNT_W(CNT_W)) u_rate (
    .clk(clk), .rst_n(rst_n_q),
    .run_set(stb.run_set), .run_clr(stb.run_clr),
    .preset_wr(stb.preset_wr), .cnt_wr(stb.cnt_wr),
    .wdata(wr_data[CNT_W-1:0]),
    .run(run), .cnt(cnt), .preset(preset), .shift_evt(shift_evt)
  );

  sss_step_tracker #(.POS_W(POS_W)) u_step (
    .clk(clk), .rst_n(rst_n_q), .shift_evt(shift_evt),
    .step_wr(stb.step_wr), .reload_wr(stb.reload_wr),
    .wdata(wr_data[POS_W-1:0]),
    .step(step), .reload(reload), .swap_evt(swap_evt)
  );

  sss_word_path #(.DATA_W(DATA_W)) u_word (
    .clk(clk), .rst_n(rst_n_q), .sin(sin),
    .shift_evt(shift_evt), .swap_evt(swap_evt),
    .live_wr(stb.live_wr), .shadow_wr(stb.shadow_wr), .wdata(wr_data),
    .live(live), .shadow(shadow)
  );

  sss_irq_flag u_irq (
    .clk(clk), .rst_n(rst_n_q), .shift_evt(shift_evt),
    .stat_set(stb.stat_set), .stat_clr(stb.stat_clr),
    .ien_set(stb.ien_set), .ien_clr(stb.ien_clr),
    .status(status), .ien(ien), .irq(irq)
  );

  assign sout = live[0];

  a_r5_sout_readback: assert property (@(posedge clk) disable iff (!rst_n_q)
    (addr == A_LIVE) |-> (sout == rd_data[0]));
  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n_q)
    irq |-> (rd_data[0] || addr != A_IEN_SET));
endmodule

// File: tb/tb_serial_shift_slice.sv
module tb_serial_shift_slice;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;

  logic        clk, rst_n, sin, sout, irq, wr_en;
  logic [3:0]  addr;
  logic [31:0] wr_data, rd_data;

  int total = 0;
  int bad   = 0;

  serial_shift_slice dut (
    .clk(clk), .rst_n(rst_n), .sin(sin), .sout(sout), .irq(irq),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  typedef struct packed {
    logic [31:0] d;
    logic        b;
    logic [7:0]  n;
    logic [7:0]  p;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{32'h0000_0001, 1'b1, 8'd1,  8'd0, 32'h8000_0000},
    '{32'hFFFF_FFFF, 1'b0, 8'd4,  8'd2, 32'h0FFF_FFFF},
    '{32'h1234_5678, 1'b0, 8'd8,  8'd1, 32'h0012_3456},
    '{32'hA5A5_A5A5, 1'b1, 8'd4,  8'd3, 32'hFA5A_5A5A},
    '{32'h0000_00F0, 1'b1, 8'd16, 8'd0, 32'hFFFF_0000}
  };

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  logic [31:0] v, v2;

  initial begin
    rst_n = 1'b0; sin = 1'b0; wr_en = 1'b0; addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 12; a++) begin
      rd(a[3:0], v);
      chk("R1 reset readback", v, 32'h0);
    end
    chk("R1 reset sout", {31'b0, sout}, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);

    // R3 R4 R5 vector table: shift count and rate
    for (int i = 0; i < NVEC; i++) begin
      wr(4'd7, 32'h1);
      wr(4'd5, 32'd255);
      wr(4'd4, 32'd255);
      wr(4'd2, {24'b0, VECS[i].p});
      wr(4'd3, 32'h0);
      wr(4'd0, VECS[i].d);
      sin = VECS[i].b;
      wr(4'd6, 32'h1);
      repeat ((int'(VECS[i].n) - 1) * (int'(VECS[i].p) + 1) + 1) @(negedge clk);
      rd(4'd0, v);
      chk("R4 R3 shifted word", v, VECS[i].e);
      chk("R5 sout bit0", {31'b0, sout}, {31'b0, VECS[i].e[0]});
    end

    // R2 countdown and R3 reload
    wr(4'd7, 32'h1);
    wr(4'd2, 32'd7);
    wr(4'd3, 32'd5);
    wr(4'd6, 32'h1);
    repeat (2) @(negedge clk);
    rd(4'd3, v);
    chk("R2 counter decrement", v, 32'd3);
    repeat (4) @(negedge clk);
    rd(4'd3, v);
    chk("R3 counter reload", v, 32'd7);

    // R6 swap
    wr(4'd7, 32'h1);
    wr(4'd2, 32'd3);
    wr(4'd3, 32'd0);
    wr(4'd5, 32'd3);
    wr(4'd4, 32'd1);
    wr(4'd1, 32'hCAFE_F00D);
    wr(4'd0, 32'h0000_0003);
    sin = 1'b1;
    wr(4'd6, 32'h1);
    repeat (5) @(negedge clk);
    rd(4'd0, v);
    chk("R6 live takes shadow", v, 32'hCAFE_F00D);
    rd(4'd1, v);
    chk("R6 shadow takes shifted live", v, 32'hC000_0000);
    rd(4'd4, v);
    chk("R6 step reload", v, 32'd3);
    chk("R5 sout after swap", {31'b0, sout}, 32'h1);

    // R10 hardware wins on a shift edge
    repeat (3) @(negedge clk);
    wr(4'd0, 32'h5555_5555);
    rd(4'd0, v);
    chk("R10 write on shift edge dropped", v, 32'hE57F_7806);
    wr(4'd0, 32'h5555_5555);
    rd(4'd0, v);
    chk("R10 write off shift edge taken", v, 32'h5555_5555);

    // R7 zero writes ignored, R2 hold while stopped
    wr(4'd7, 32'h1);
    wr(4'd6, 32'h0);
    rd(4'd6, v);
    chk("R7 set with zero ignored", v, 32'h0);
    rd(4'd3, v);
    repeat (3) @(negedge clk);
    rd(4'd3, v2);
    chk("R2 hold while stopped", v2, v);
    wr(4'd6, 32'h1);
    wr(4'd7, 32'h0);
    rd(4'd7, v);
    chk("R7 clear with zero ignored", v, 32'h1);
    wr(4'd7, 32'h1);
    rd(4'd7, v);
    chk("R7 clear stops", v, 32'h0);

    // R8 R9 status and enable
    wr(4'd9, 32'h1);
    wr(4'd11, 32'h1);
    rd(4'd10, v);
    chk("R8 status clear", v, 32'h0);
    wr(4'd10, 32'h1);
    rd(4'd11, v);
    chk("R8 status set", v, 32'h1);
    chk("R9 irq gated by enable", {31'b0, irq}, 32'h0);
    wr(4'd8, 32'h1);
    rd(4'd9, v);
    chk("R9 enable readback", v, 32'h1);
    chk("R9 irq on", {31'b0, irq}, 32'h1);
    wr(4'd9, 32'h1);
    chk("R9 irq off after enable clear", {31'b0, irq}, 32'h0);
    wr(4'd11, 32'h1);
    wr(4'd8, 32'h1);
    wr(4'd2, 32'd20);
    wr(4'd3, 32'd0);
    wr(4'd6, 32'h1);
    @(negedge clk);
    rd(4'd10, v);
    chk("R8 shift step sets status", v, 32'h1);
    chk("R9 irq from shift step", {31'b0, irq}, 32'h1);
    wr(4'd11, 32'h1);
    repeat (19) @(negedge clk);
    wr(4'd11, 32'h1);
    rd(4'd10, v);
    chk("R8 step beats clear", v, 32'h1);
    wr(4'd11, 32'h1);
    rd(4'd10, v);
    chk("R8 clear off step edge", v, 32'h0);
    rd(4'd8, v);
    chk("R11 enable at address 8", v, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule